// File: doc/BRIEF.md
# Inter-Processor Interrupt Destination Resolver

This block sits beside a cluster of local interrupt units and turns one interrupt command into the set of units that must receive it. A command carries an 8-bit destination, a bit that selects physical or logical addressing, a 2-bit shorthand, a lowest-priority flag and the index of the unit that sent it. Every unit supplies its physical ID, its logical ID, its logical addressing format, an enable bit and a presence bit. The result is a mask with one bit per unit, along with a flag that is raised when the command reaches nobody.

For ordinary delivery the mask holds every unit the address selects. For lowest-priority delivery the block keeps a rotating pointer. It picks exactly one unit: the first one after the pointer that both matches and is enabled. It then moves the pointer to that unit when the command strobe is seen. The whole resolution is combinational in the cycle the command is valid. Only the pointer is state.

Top module: `ipi_dest_resolver`

## Requirements
- R1: With shorthand 0 (none) and the logical bit low, a present unit is selected when the destination equals its physical ID or when the destination is 0xFF.
- R2: With shorthand 0, the logical bit high and the unit format 2'b00 (flat), a present unit is selected when its logical ID ANDed with the destination is nonzero.
- R3: With shorthand 0, the logical bit high and the unit format 2'b01 (cluster), a present unit is selected when bits 7:4 of its logical ID equal bits 7:4 of the destination and bits 3:0 of the two values share at least one set bit.
- R4: In logical addressing, a unit whose format is 2'b10 or 2'b11 is never selected.
- R5: Shorthand 1 (self) selects only the source unit, whatever the destination and addressing bit are.
- R6: Shorthand 2 (all including self) selects every present unit.
- R7: Shorthand 3 (all excluding self) selects every present unit except the source.
- R8: A unit whose presence bit is low is never selected, under any shorthand or delivery.
- R9: When the lowest-priority flag is set, the mask holds at most one bit. That bit belongs to the first unit, searched from pointer+1 upward and wrapping modulo N, that is both selected by R1 to R8 and enabled. Without the flag, the enable bits have no effect on the mask.
- R10: A valid lowest-priority command that finds a unit moves the pointer to that unit at the next clock edge. One that finds none leaves the pointer unchanged. no_target is high while a valid command yields an empty mask.
- R11: While cmd_valid is low, target_mask is all zero and no_target is low. After reset the pointer is N-1, so the first lowest-priority search begins at unit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe; the pointer advances on it |
| cmd_dest | input | 8 | Destination address |
| cmd_logical | input | 1 | 0 = physical, 1 = logical addressing |
| cmd_short | input | 2 | 0 none, 1 self, 2 all including self, 3 all excluding self |
| cmd_lowest | input | 1 | Lowest-priority delivery: pick one unit round robin |
| cmd_src | input | $clog2(N_UNITS) | Index of the sending unit |
| unit_id | input | 8*N_UNITS | Physical IDs, unit i in bits 8i+7:8i |
| unit_lid | input | 8*N_UNITS | Logical IDs, unit i in bits 8i+7:8i |
| unit_fmt | input | 2*N_UNITS | Logical format per unit: 00 flat, 01 cluster, others invalid |
| unit_enable | input | N_UNITS | Unit may take lowest-priority deliveries |
| unit_present | input | N_UNITS | Unit exists |
| target_mask | output | N_UNITS | Selected units |
| no_target | output | 1 | Valid command reached no unit |

## Verification
The bench goes after the wrap of the round-robin search past the top index, searches that find nothing, broadcast address 0xFF, cluster IDs whose high nibble matches but whose low nibbles do not overlap, units with an invalid format, and absent units under every shorthand. A design that moved the pointer on a failed search would send the next pick to the wrong unit. A design that tested only the low nibble in cluster mode would select units from a foreign cluster. A design that ignored presence or enable would target a missing or disabled unit, or return two units for lowest-priority delivery. Random commands over varied configurations then compare every mask against an independent model.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  typedef enum logic [1:0] {
    SH_NONE    = 2'd0,
    SH_SELF    = 2'd1,
    SH_ALL_INC = 2'd2,
    SH_ALL_EXC = 2'd3
  } shorthand_e;

  localparam logic [1:0] FMT_FLAT    = 2'b00;
  localparam logic [1:0] FMT_CLUSTER = 2'b01;
  localparam logic [7:0] DEST_BCAST  = 8'hFF;

  // Flat logical: any shared bit selects the unit.
  function automatic logic flat_hit(input logic [7:0] dest, input logic [7:0] lid);
    return |(dest & lid);
  endfunction

  // Cluster logical: same cluster nibble and a shared member bit.
  function automatic logic cluster_hit(input logic [7:0] dest, input logic [7:0] lid);
    return (dest[7:4] == lid[7:4]) && (|(dest[3:0] & lid[3:0]));
  endfunction

  // Address match without shorthand (R1..R4).
  function automatic logic addr_hit(input logic [7:0] dest, input logic logical,
                                    input logic [7:0] pid, input logic [7:0] lid,
                                    input logic [1:0] fmt);
    if (!logical) return (dest == DEST_BCAST) || (dest == pid);
    case (fmt)
      FMT_FLAT:    return flat_hit(dest, lid);
      FMT_CLUSTER: return cluster_hit(dest, lid);
      default:     return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ipi_unit_match.sv
module ipi_unit_match
  import ipi_pkg::*;
#(
  parameter int N_UNITS  = 8,
  parameter int UNIT_IDX = 0,
  localparam int IDXW    = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic [7:0]      dest,
  input  logic            logical,
  input  logic [1:0]      short_sel,
  input  logic [IDXW-1:0] src,
  input  logic [7:0]      pid,
  input  logic [7:0]      lid,
  input  logic [1:0]      fmt,
  input  logic            present,
  output logic            hit
);

  logic is_src;
  logic raw_hit;

  assign is_src = (src == IDXW'(UNIT_IDX));

  always_comb begin
    case (shorthand_e'(short_sel))
      SH_NONE:    raw_hit = addr_hit(dest, logical, pid, lid, fmt);
      SH_SELF:    raw_hit = is_src;
      SH_ALL_INC: raw_hit = 1'b1;
      default:    raw_hit = !is_src;
    endcase
  end

  // R8: absence overrides every shorthand
  assign hit = present && raw_hit;

endmodule

// File: rtl/ipi_rr_pick.sv
module ipi_rr_pick #(
  parameter int N_UNITS = 8,
  localparam int IDXW   = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               advance,
  input  logic [N_UNITS-1:0] cand,
  output logic [N_UNITS-1:0] pick_mask,
  output logic               found
);

  logic [IDXW-1:0] ptr_q;
  logic [IDXW-1:0] pick_idx;

  // Search pointer+1 .. pointer+N, wrapping, first candidate wins (R9).
  always_comb begin
    found     = 1'b0;
    pick_idx  = ptr_q;
    pick_mask = '0;
    for (int k = 1; k <= N_UNITS; k++) begin
      int j;
      j = int'(ptr_q) + k;
      if (j >= N_UNITS) j = j - N_UNITS;
      if (!found && cand[j]) begin
        found        = 1'b1;
        pick_idx     = IDXW'(j);
        pick_mask[j] = 1'b1;
      end
    end
  end

  // R10: pointer follows a successful pick, holds otherwise. R11: reset to N-1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ptr_q <= IDXW'(N_UNITS - 1);
    else if (advance && found) ptr_q <= pick_idx;
  end

  assert_ptr_follows_pick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && found) |=> (ptr_q == $past(pick_idx)));

  assert_ptr_holds_on_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !found) |=> $stable(ptr_q));

  assert_pick_is_candidate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (((pick_mask & ~cand) == '0) && $onehot(pick_mask)));

endmodule

// File: rtl/ipi_dest_resolver.sv
module ipi_dest_resolver
  import ipi_pkg::*;
#(
  parameter int N_UNITS = 8,
  localparam int IDXW   = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [7:0]           cmd_dest,
  input  logic                 cmd_logical,
  input  logic [1:0]           cmd_short,
  input  logic                 cmd_lowest,
  input  logic [IDXW-1:0]      cmd_src,
  input  logic [8*N_UNITS-1:0] unit_id,
  input  logic [8*N_UNITS-1:0] unit_lid,
  input  logic [2*N_UNITS-1:0] unit_fmt,
  input  logic [N_UNITS-1:0]   unit_enable,
  input  logic [N_UNITS-1:0]   unit_present,
  output logic [N_UNITS-1:0]   target_mask,
  output logic                 no_target
);

  logic [N_UNITS-1:0] hit_vec;
  logic [N_UNITS-1:0] lp_cand;
  logic [N_UNITS-1:0] lp_mask;
  logic               lp_found;
  logic               lp_advance;

  for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
    ipi_unit_match #(.N_UNITS(N_UNITS), .UNIT_IDX(g)) u_match (
      .dest      (cmd_dest),
      .logical   (cmd_logical),
      .short_sel (cmd_short),
      .src       (cmd_src),
      .pid       (unit_id[8*g +: 8]),
      .lid       (unit_lid[8*g +: 8]),
      .fmt       (unit_fmt[2*g +: 2]),
      .present   (unit_present[g]),
      .hit       (hit_vec[g])
    );
  end

  assign lp_cand    = hit_vec & unit_enable;
  assign lp_advance = cmd_valid && cmd_lowest;

  ipi_rr_pick #(.N_UNITS(N_UNITS)) u_rr (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (lp_advance),
    .cand      (lp_cand),
    .pick_mask (lp_mask),
    .found     (lp_found)
  );

  always_comb begin
    if (!cmd_valid)      target_mask = '0;
    else if (cmd_lowest) target_mask = lp_mask;
    else                 target_mask = hit_vec;
  end

  assign no_target = cmd_valid && (target_mask == '0);

  assert_absent_never_targeted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ((target_mask & ~unit_present) == '0));

  assert_self_only_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_short == SH_SELF) |-> ((target_mask & ~(N_UNITS'(1) << cmd_src)) == '0));

  assert_excl_skips_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_short == SH_ALL_EXC) |-> !target_mask[cmd_src]);

  assert_lowest_single_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lp_advance |-> ($onehot0(target_mask) && ((target_mask & ~unit_enable) == '0)));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> ((target_mask == '0) && !no_target));

endmodule

// File: tb/ipi_dest_resolver_tb.sv
module ipi_dest_resolver_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int IW = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic [7:0]       cmd_dest = '0;
  logic             cmd_logical = 1'b0;
  logic [1:0]       cmd_short = '0;
  logic             cmd_lowest = 1'b0;
  logic [IW-1:0]    cmd_src = '0;
  logic [8*N-1:0]   unit_id = '0;
  logic [8*N-1:0]   unit_lid = '0;
  logic [2*N-1:0]   unit_fmt = '0;
  logic [N-1:0]     unit_enable = '1;
  logic [N-1:0]     unit_present = '1;
  logic [N-1:0]     target_mask;
  logic             no_target;

  ipi_dest_resolver #(.N_UNITS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_dest(cmd_dest),
    .cmd_logical(cmd_logical), .cmd_short(cmd_short), .cmd_lowest(cmd_lowest),
    .cmd_src(cmd_src), .unit_id(unit_id), .unit_lid(unit_lid), .unit_fmt(unit_fmt),
    .unit_enable(unit_enable), .unit_present(unit_present),
    .target_mask(target_mask), .no_target(no_target)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [N-1:0] mask;
    logic         nt;
    string        req;
  } exp_t;

  exp_t q[$];
  int   applied = 0;
  int   miscompares = 0;
  int   model_ptr = N - 1;
  bit   done = 1'b0;

  // Independent model of one unit's selection.
  function automatic bit model_sel(int u, logic [1:0] sh, logic lg, logic [7:0] d, int src);
    logic [7:0] pid, lid;
    logic [1:0] f;
    bit r;
    pid = unit_id[8*u +: 8];
    lid = unit_lid[8*u +: 8];
    f   = unit_fmt[2*u +: 2];
    if (!unit_present[u]) return 0;                   // R8
    if (sh == 2'd1) return (u == src);                // R5
    if (sh == 2'd2) return 1;                         // R6
    if (sh == 2'd3) return (u != src);                // R7
    if (!lg) return (d == 8'd255) || (d == pid);      // R1
    r = 0;
    if (f == 2'b00) begin                             // R2
      for (int b = 0; b < 8; b++) if (d[b] && lid[b]) r = 1;
    end else if (f == 2'b01) begin                    // R3
      if ((d / 16) == (lid / 16))
        for (int b = 0; b < 4; b++) if (d[b] && lid[b]) r = 1;
    end                                               // R4: other formats stay 0
    return r;
  endfunction

  task automatic send(input logic lw, input logic [1:0] sh, input logic lg,
                      input logic [7:0] d, input int src, input string req);
    exp_t e;
    logic [N-1:0] m;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_lowest = lw; cmd_short = sh; cmd_logical = lg;
    cmd_dest = d; cmd_src = IW'(src);
    for (int u = 0; u < N; u++) m[u] = model_sel(u, sh, lg, d, src);
    if (lw) begin                                     // R9 / R10
      logic [N-1:0] one;
      one = '0;
      for (int s = 1; s <= N; s++) begin
        int c;
        c = (model_ptr + s) % N;
        if (one == '0 && m[c] && unit_enable[c]) one[c] = 1'b1;
      end
      m = one;
      for (int u = 0; u < N; u++) if (one[u]) model_ptr = u;
    end
    e.mask = m; e.nt = (m == '0); e.req = req;
    q.push_back(e);
    @(posedge clk); #1;
  endtask

  task automatic idle(input string req);
    exp_t e;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_lowest = 1'b1; cmd_short = 2'd2;              // inputs that would select if valid
    e.mask = '0; e.nt = 1'b0; e.req = req;
    q.push_back(e);
    @(posedge clk); #1;
  endtask

  // Monitor: compare a quarter period after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        applied++;
        if (target_mask !== e.mask || no_target !== e.nt) begin
          miscompares++;
          $display("FAIL %s mask=%b nt=%b expected mask=%b nt=%b",
                   e.req, target_mask, no_target, e.mask, e.nt);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      miscompares++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    for (int u = 0; u < N; u++) begin
      unit_id[8*u +: 8]  = 8'h10 + 8'(u);
      unit_lid[8*u +: 8] = 8'(1 << u);
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    idle("R11");                                      // reset / idle state
    send(0, 2'd0, 0, 8'h13, 0, "R1");                 // unit 3
    send(0, 2'd0, 0, 8'hFF, 0, "R1");                 // broadcast
    send(0, 2'd0, 0, 8'h55, 0, "R10");                // nobody: no_target
    send(0, 2'd0, 1, 8'h05, 0, "R2");                 // flat units 0,2
    unit_fmt[2*2 +: 2] = 2'b10;
    send(0, 2'd0, 1, 8'h05, 0, "R4");                 // unit 2 invalid format
    unit_fmt[2*2 +: 2] = 2'b11;
    send(0, 2'd0, 1, 8'h04, 0, "R4");
    for (int u = 0; u < N; u++) begin
      unit_fmt[2*u +: 2] = 2'b01;
      unit_lid[8*u +: 8] = {4'(u / 4), 4'(1 << (u % 4))};
    end
    send(0, 2'd0, 1, 8'h13, 0, "R3");                 // cluster 1 members 0,1
    send(0, 2'd0, 1, 8'h0F, 0, "R3");                 // cluster 0 all
    send(0, 2'd0, 1, 8'h20, 0, "R3");                 // foreign cluster
    send(0, 2'd1, 0, 8'h11, 5, "R5");
    send(0, 2'd2, 1, 8'h00, 5, "R6");
    send(0, 2'd3, 0, 8'hFF, 5, "R7");
    unit_present[1] = 1'b0;
    send(0, 2'd2, 0, 8'h00, 0, "R8");
    send(0, 2'd1, 0, 8'h00, 1, "R8");
    send(1, 2'd2, 0, 8'h00, 0, "R11");                // first pick after reset: unit 0
    send(1, 2'd2, 0, 8'h00, 0, "R9");                 // skips absent unit 1 -> 2
    unit_enable = 8'b1000_0001;
    send(1, 2'd2, 0, 8'h00, 0, "R9");                 // -> 7
    send(1, 2'd2, 0, 8'h00, 0, "R9");                 // wraps -> 0
    unit_enable = '0;
    send(1, 2'd2, 0, 8'h00, 0, "R10");                // miss, pointer held
    unit_enable = '1;
    send(1, 2'd0, 0, 8'hFF, 0, "R10");                // resumes at 2
    unit_enable = 8'b0000_0100;
    send(0, 2'd2, 0, 8'h00, 0, "R9");                 // enable ignored without flag

    for (int i = 0; i < 300; i++) begin
      for (int u = 0; u < N; u++) begin
        unit_id[8*u +: 8]  = 8'($urandom_range(0, 7));
        unit_lid[8*u +: 8] = 8'($urandom);
        unit_fmt[2*u +: 2] = ($urandom_range(0, 9) == 0) ? 2'b10 : 2'($urandom_range(0, 1));
      end
      unit_enable  = N'($urandom);
      unit_present = N'($urandom) | N'($urandom);
      if ($urandom_range(0, 7) == 0) idle("R11");
      else begin
        logic lw;
        lw = 1'($urandom);
        send(lw, 2'($urandom), 1'($urandom),
             ($urandom_range(0, 5) == 0) ? 8'hFF : 8'($urandom_range(0, 63)),
             $urandom_range(0, N - 1), lw ? "R9" : "R1");
      end
    end

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule